// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one DMA channel. Software programs a source pointer, a destination pointer, a unit counter and a control byte through a small register port. Each hardware request then moves exactly one unit: one memory read cycle from the source pointer, then one memory write cycle to the destination pointer. Units are 8 or 16 bits wide. Each pointer either stays fixed or moves forward after every unit. At most one of the two pointers may move forward.

When the counter runs out, single mode turns the channel off. Repeat mode restores the counter and both pointers from the values software last wrote, and leaves the channel on. In both modes the block emits a one-cycle completion pulse. Software can clear the pending-request flag but cannot set it. Only the request input sets it, and only while the channel is enabled.

Register map (reg_addr): 0 = control, 1 = source pointer, 2 = destination pointer, 3 = unit counter. Reads are combinational.

Top module: `dma_channel`

## Requirements
- R1: After reset the control, source, destination and counter registers all read 0. Control bits above bit 5 always read 0, and writes to them have no effect.
- R2: Control bit 4 (source forward) and bit 5 (destination forward) are never both 1. A write that has both set keeps the previous values of those two bits but applies its other fields.
- R3: The pending flag (control bit 2) is set only by dma_req while the enable bit (bit 3) is 1. A software write of 1 to bit 2 does not set it, and dma_req is ignored while the channel is disabled.
- R4: A pending, enabled channel performs one read cycle (mem_rd, mem_addr = source), then one write cycle (mem_wr, mem_addr = destination) carrying the data read. mem_byte equals control bit 0 (1 = 8-bit). In 8-bit units the upper 8 bits of mem_wdata are 0.
- R5: After each unit, a pointer whose forward bit is 1 advances by 1 for 8-bit units and by 2 for 16-bit units. A pointer whose forward bit is 0 is unchanged.
- R6: The pending flag clears, and the counter decrements by one, at the end of each unit's write cycle.
- R7: In single mode (bit 1 = 0), the unit that takes the counter from 1 to 0 clears the enable bit. The done output pulses high for one cycle right after that write, and the channel then ignores further requests.
- R8: In repeat mode (bit 1 = 1), the last unit reloads the counter and both pointers from the values last written by software and keeps the enable bit set. done pulses for one cycle, and the next request starts again from the reloaded source.
- R9: done is low after every unit that is not the last one of a block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | RW | Register write data |
| reg_rdata | output | RW | Register read data (combinational) |
| dma_req | input | 1 | Hardware transfer request |
| done | output | 1 | Block-complete pulse |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_byte | output | 1 | 1 = 8-bit unit, 0 = 16-bit unit |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid in the read cycle |

## Verification
A wrong pointer or step shows up on mem_addr in the very next unit's read or write cycle, two to three cycles after the request. A wrong counter shows up either as a done pulse after the wrong unit or as a wrong reload, which is visible one request later. A pending flag that software could set, or that failed to clear, produces memory strobes with no request behind them within two cycles. Control field corruption shows up immediately on a control register read.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_SRC  = 2'd1;
    localparam logic [1:0] REG_DST  = 2'd2;
    localparam logic [1:0] REG_CNT  = 2'd3;

    // bit 5 .. bit 0
    typedef struct packed {
        logic dst_fwd;
        logic src_fwd;
        logic en;
        logic pend;
        logic rpt;
        logic byte_unit;
    } ctrl_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } xfer_st_t;

    // software write: pend may only be cleared; a write with both forward bits set keeps the old pair
    function automatic ctrl_t ctrl_sw_update(ctrl_t cur, logic [7:0] wd);
        ctrl_t nxt;
        nxt           = cur;
        nxt.byte_unit = wd[0];
        nxt.rpt       = wd[1];
        nxt.pend      = cur.pend & wd[2];
        nxt.en        = wd[3];
        if (!(wd[4] && wd[5])) begin
            nxt.src_fwd = wd[4];
            nxt.dst_fwd = wd[5];
        end
        return nxt;
    endfunction

endpackage

// File: rtl/dmach_ptr.sv
module dmach_ptr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic         adv,
    input  logic         fwd,
    input  logic         byte_unit,
    input  logic         reload,
    output logic [W-1:0] q
);
    logic [W-1:0] shadow_q;
    logic [W-1:0] step;

    assign step = byte_unit ? W'(1) : W'(2);

    always_ff @(posedge clk) begin
        if (rst) begin
            q        <= '0;
            shadow_q <= '0;
        end else if (ld) begin
            q        <= ld_val;
            shadow_q <= ld_val;
        end else if (reload) begin
            q <= shadow_q;
        end else if (adv && fwd) begin
            q <= q + step;
        end
    end
endmodule

// File: rtl/dmach_regs.sv
module dmach_regs
    import dmach_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int RW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [RW-1:0] reg_wdata,
    output logic [RW-1:0] reg_rdata,
    input  logic          dma_req,
    input  logic          unit_done,
    output ctrl_t         ctrl_o,
    output logic [AW-1:0] src_o,
    output logic [AW-1:0] dst_o,
    output logic          done_o
);
    ctrl_t         ctrl_q, ctrl_d;
    logic [CW-1:0] cnt_q, cnt_sh_q;
    logic          last_unit, reload;
    logic [AW-1:0] ptr_q [2];

    assign last_unit = (cnt_q == CW'(1));
    assign reload    = unit_done && last_unit && ctrl_q.rpt;

    always_comb begin
        ctrl_d = ctrl_q;
        if (reg_wr && reg_addr == REG_CTRL) ctrl_d = ctrl_sw_update(ctrl_q, reg_wdata[7:0]);
        if (unit_done) begin
            ctrl_d.pend = 1'b0;
            if (last_unit && !ctrl_q.rpt) ctrl_d.en = 1'b0;
        end
        if (dma_req && ctrl_d.en) ctrl_d.pend = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            cnt_q    <= '0;
            cnt_sh_q <= '0;
            done_o   <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
            done_o <= unit_done && last_unit;
            if (reg_wr && reg_addr == REG_CNT) begin
                cnt_q    <= CW'(reg_wdata);
                cnt_sh_q <= CW'(reg_wdata);
            end else if (unit_done) begin
                cnt_q <= reload ? cnt_sh_q : cnt_q - CW'(1);
            end
        end
    end

    for (genvar gi = 0; gi < 2; gi++) begin : g_ptr
        localparam logic [1:0] SEL = (gi == 0) ? REG_SRC : REG_DST;
        dmach_ptr #(.W(AW)) u_ptr (
            .clk       (clk),
            .rst       (rst),
            .ld        (reg_wr && reg_addr == SEL),
            .ld_val    (AW'(reg_wdata)),
            .adv       (unit_done),
            .fwd       ((gi == 0) ? ctrl_q.src_fwd : ctrl_q.dst_fwd),
            .byte_unit (ctrl_q.byte_unit),
            .reload    (reload),
            .q         (ptr_q[gi])
        );
    end

    assign src_o  = ptr_q[0];
    assign dst_o  = ptr_q[1];
    assign ctrl_o = ctrl_q;

    always_comb begin
        case (reg_addr)
            REG_CTRL: reg_rdata = RW'({2'b00, ctrl_q});
            REG_SRC:  reg_rdata = RW'(ptr_q[0]);
            REG_DST:  reg_rdata = RW'(ptr_q[1]);
            default:  reg_rdata = RW'(cnt_q);
        endcase
    end
endmodule

// File: rtl/dmach_xfer.sv
module dmach_xfer
    import dmach_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          byte_unit,
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] dst_i,
    input  logic [15:0]   mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          mem_byte,
    output logic [15:0]   mem_wdata,
    output logic          unit_done
);
    xfer_st_t    st_q;
    logic [15:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            data_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (start) st_q <= ST_RD;
                ST_RD: begin
                    data_q <= mem_rdata;
                    st_q   <= ST_WR;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_rd    = (st_q == ST_RD);
    assign mem_wr    = (st_q == ST_WR);
    assign unit_done = mem_wr;
    assign mem_addr  = mem_wr ? dst_i : src_i;
    assign mem_byte  = byte_unit;
    assign mem_wdata = byte_unit ? {8'h00, data_q[7:0]} : data_q;
endmodule

// File: rtl/dma_channel.sv
module dma_channel
    import dmach_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int RW = (AW > CW) ? AW : CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [RW-1:0] reg_wdata,
    output logic [RW-1:0] reg_rdata,
    input  logic          dma_req,
    output logic          done,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          mem_byte,
    output logic [15:0]   mem_wdata,
    input  logic [15:0]   mem_rdata
);
    ctrl_t         ctrl_w;
    logic [AW-1:0] src_w, dst_w;
    logic          unit_done_w;

    dmach_regs #(.AW(AW), .CW(CW), .RW(RW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .dma_req   (dma_req),
        .unit_done (unit_done_w),
        .ctrl_o    (ctrl_w),
        .src_o     (src_w),
        .dst_o     (dst_w),
        .done_o    (done)
    );

    dmach_xfer #(.AW(AW)) u_xfer (
        .clk       (clk),
        .rst       (rst),
        .start     (ctrl_w.pend && ctrl_w.en),
        .byte_unit (ctrl_w.byte_unit),
        .src_i     (src_w),
        .dst_i     (dst_w),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_byte  (mem_byte),
        .mem_wdata (mem_wdata),
        .unit_done (unit_done_w)
    );
endmodule

// File: rtl/dma_channel_chk.sv
module dma_channel_chk #(
    parameter int RW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    reg_addr,
    input logic [RW-1:0] reg_rdata,
    input logic          dma_req,
    input logic          done,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [5:0]    ctrl_bits
);
    // R4
    rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R4
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> $past(mem_rd));

    // R7
    done_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(mem_wr));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3
    pend_hw_only_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl_bits[2]) |-> $past(dma_req));

    // R2
    dir_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ctrl_bits[4] && ctrl_bits[5]));

    // R1
    top_bits_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == 2'd0) |-> (reg_rdata[RW-1:6] == '0));
endmodule

bind dma_channel dma_channel_chk #(.RW(RW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .dma_req   (dma_req),
    .done      (done),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .ctrl_bits (ctrl_w)
);

// File: tb/sim_dma_channel.sv
module sim_dma_channel;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        dma_req = 1'b0;
    logic        done;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr, mem_byte;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    // memory model: contents are a fixed function of the address
    assign mem_rdata = mem_addr ^ 16'hA5C3;

    dma_channel u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_req(dma_req),
        .done(done), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_byte(mem_byte), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    typedef struct packed {
        logic [7:0]  ctrl;
        logic [15:0] src, dst, cnt;
        logic [15:0] esrc, edst, ecnt;
        logic [7:0]  ectrl;
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VECS [NV] = '{
        '{8'h18, 16'h0100, 16'h0200, 16'd3, 16'h0106, 16'h0200, 16'd0, 8'h10},
        '{8'h29, 16'h0040, 16'h0300, 16'd2, 16'h0040, 16'h0302, 16'd0, 8'h21},
        '{8'h1A, 16'h0010, 16'h0080, 16'd2, 16'h0010, 16'h0080, 16'd2, 8'h1A},
        '{8'h2B, 16'h0020, 16'h0050, 16'd3, 16'h0020, 16'h0050, 16'd3, 8'h2B},
        '{8'h08, 16'h0004, 16'h0006, 16'd1, 16'h0004, 16'h0006, 16'd0, 8'h00}
    };

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 2'd0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // fire one request and check the resulting read and write cycles and done
    task automatic fire_unit(input logic [15:0] sa, input logic [15:0] da, input bit bu,
                             input bit last, input string req);
        logic [15:0] ed;
        ed = bu ? {8'h00, (sa ^ 16'hA5C3) & 16'h00FF} : (sa ^ 16'hA5C3);
        @(negedge clk); dma_req = 1'b1;
        @(negedge clk); dma_req = 1'b0;
        @(negedge clk);
        check(mem_rd && !mem_wr, {req, " R4 read cycle"}, {15'd0, mem_rd}, 16'd1);
        check(mem_addr == sa, {req, " R4/R5 read addr"}, mem_addr, sa);
        check(mem_byte == bu, "R4 unit size", {15'd0, mem_byte}, {15'd0, bu});
        @(negedge clk);
        check(mem_wr && !mem_rd, {req, " R4 write cycle"}, {15'd0, mem_wr}, 16'd1);
        check(mem_addr == da, {req, " R4/R5 write addr"}, mem_addr, da);
        check(mem_wdata == ed, "R4 write data", mem_wdata, ed);
        @(negedge clk);
        check(done == last, last ? "R7/R8 done pulse" : "R9 no done", {15'd0, done}, {15'd0, last});
        @(negedge clk);
        check(!done && !mem_rd, "R9 done one cycle, R6 no second unit", {14'd0, done, mem_rd}, 16'd0);
    endtask

    task automatic quiet_cycles(input int n, input string req);
        bit seen;
        seen = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (mem_rd || mem_wr) seen = 1;
        end
        check(!seen, req, {15'd0, seen}, 16'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            reg_read(2'(a), rd);
            check(rd == 16'h0, "R1 reset value", rd, 16'h0);
        end
        check(!mem_rd && !mem_wr && !done, "R1 idle outputs", {13'd0, mem_rd, mem_wr, done}, 16'd0);

        // vector table
        for (int v = 0; v < NV; v++) begin
            vec_t t;
            logic [15:0] sp, dp;
            bit bu;
            logic [15:0] stp;
            t = VECS[v];
            bu = t.ctrl[0];
            stp = bu ? 16'd1 : 16'd2;
            reg_write(2'd1, t.src);
            reg_write(2'd2, t.dst);
            reg_write(2'd3, t.cnt);
            reg_write(2'd0, {8'h00, t.ctrl});
            sp = t.src;
            dp = t.dst;
            for (int u = 0; u < int'(t.cnt); u++) begin
                fire_unit(sp, dp, bu, (u == int'(t.cnt) - 1), "vec");
                if (t.ctrl[4]) sp = sp + stp;
                if (t.ctrl[5]) dp = dp + stp;
                if (u < int'(t.cnt) - 1) begin
                    reg_read(2'd3, rd);
                    check(rd == t.cnt - 16'(u + 1), "R6 counter decrement", rd, t.cnt - 16'(u + 1));
                end
            end
            reg_read(2'd1, rd); check(rd == t.esrc, "R5/R8 final source", rd, t.esrc);
            reg_read(2'd2, rd); check(rd == t.edst, "R5/R8 final dest", rd, t.edst);
            reg_read(2'd3, rd); check(rd == t.ecnt, "R7/R8 final count", rd, t.ecnt);
            reg_read(2'd0, rd); check(rd == {8'h00, t.ectrl}, "R6/R7/R8 final control", rd, {8'h00, t.ectrl});
            if (t.ctrl[1]) begin
                // R8 restart from reloaded pointers
                fire_unit(t.src, t.dst, bu, (t.cnt == 16'd1), "R8 after reload");
            end else begin
                // R7 channel now off: request ignored
                @(negedge clk); dma_req = 1'b1;
                @(negedge clk); dma_req = 1'b0;
                quiet_cycles(4, "R7 request after block ignored");
            end
            reg_write(2'd0, 16'h0000);
        end

        // R1 upper bits ignored
        reg_write(2'd0, 16'h00C8);
        reg_read(2'd0, rd); check(rd == 16'h0008, "R1 upper bits", rd, 16'h0008);

        // R3 software cannot set the pending flag
        reg_write(2'd0, 16'h000C);
        reg_read(2'd0, rd); check(rd == 16'h0008, "R3 sw set of flag", rd, 16'h0008);
        quiet_cycles(4, "R3 no transfer from sw flag write");

        // R3 request while disabled ignored
        reg_write(2'd0, 16'h0000);
        @(negedge clk); dma_req = 1'b1;
        @(negedge clk); dma_req = 1'b0;
        reg_read(2'd0, rd); check(rd == 16'h0000, "R3 req while disabled", rd, 16'h0000);
        reg_write(2'd0, 16'h0008);
        quiet_cycles(4, "R3 no late transfer after enable");

        // R2 both forward bits rejected
        reg_write(2'd0, 16'h0010);
        reg_write(2'd0, 16'h0039);
        reg_read(2'd0, rd); check(rd == 16'h0019, "R2 keep src dir", rd, 16'h0019);
        reg_write(2'd0, 16'h0020);
        reg_write(2'd0, 16'h0030);
        reg_read(2'd0, rd); check(rd == 16'h0020, "R2 keep dst dir", rd, 16'h0020);
        reg_write(2'd0, 16'h0000);

        finish_run();
    end
endmodule